// File: doc/BRIEF.md
# FM Operator Envelope Generator

This block produces the attenuation envelope of one operator in an FM synthesizer. A 7-bit attenuation level moves through five phases: dump, attack, decay, sustain and release. Higher values are quieter, and 127 is silence. A free-running envelope counter outside the block is shared by all operators. Each phase has an effective rate, and that rate picks two things from the counter: the clock edges on which the level may change, and how large each change is. The size comes from a 16-step increment pattern indexed by counter bits.

Raising the key starts a dump phase, which drives the level up to silence at a fixed internal rate. When the level reaches silence, the attack phase starts in the same step. Attack is exponential and brings the level down to zero. At the fastest attack rates the attack phase is skipped. Decay then raises the level until its upper four bits match the sustain level. Sustain holds the level, unless percussive mode is set, in which case the level keeps rising at the release rate. Lowering the key sends the envelope to release from any phase.

Phase codes on `eg_phase`:

| Code | Phase |
|------|-------|
| 0 | DUMP |
| 1 | ATTACK |
| 2 | DECAY |
| 3 | SUSTAIN |
| 4 | RELEASE |

Phase transitions:

| From | To | Condition |
|------|----|-----------|
| any | DUMP | key rise |
| any except RELEASE | RELEASE | key low |
| DUMP | ATTACK | level reaches max |
| ATTACK | DECAY | level reaches zero, or the attack rate is the fastest group |
| DECAY | SUSTAIN | sustain compare matches |

Top module: `eg_operator`

## Requirements
- R1: After reset, `eg_phase` is RELEASE (4) and `eg_att` is 127.
- R2: Each rate is 6 bits. Its upper four bits form the rate group `g`, and its lower two bits form the sub-rate `s`. Group 0 never updates. Groups 1 to 12 use `sh = 13 - g`, and groups 13 to 15 use `sh = 0`. An update fires only on a clock where the low `sh` bits of `eg_cnt` are all zero.
- R3: The pattern step is `k = (eg_cnt >> sh) mod 16`. For groups 1 to 12 the increment is:
  - `s = 0`: 1 when `k` is odd.
  - `s = 1`: 1 when `k` is odd or `k mod 8 = 4`.
  - `s = 2`: 1 when `k` is odd or `k mod 4 = 2`.
  - `s = 3`: 1 when `k mod 8 != 0`.
  - Otherwise the increment is 0.
- R4: Group 13 gives 1 when `k` is odd. With `s = 1` it also gives 1 for `k` in 4 to 7. With `s = 2` it also gives 1 for `k` in {4..7, 12..15}. With `s = 3` it also gives 1 for `k >= 4`. Otherwise group 13 gives 0. Group 14 gives 1, plus the same extra term for `s` 1 to 3. Group 15 gives 2.
- R5: A rising `key_on` makes the phase DUMP on the next clock and leaves the level unchanged for that clock.
- R6: In DUMP, the level adds the increment of the internal dump rate and saturates at 127. On the clock where the new level equals 127, the phase becomes ATTACK.
- R7: In ATTACK with group 1 to 14, each update subtracts `d = ((att+1)*inc + 3) >> 2`. If `d >= att`, or the level is already 0, the level becomes 0 and the phase becomes DECAY.
- R8: In ATTACK with attack group 15, the level becomes 0 and the phase becomes DECAY in one clock.
- R9: In DECAY, the level adds the decay increment and saturates at 127. On the clock where bits [6:3] of the new level equal `sus_lvl`, the phase becomes SUSTAIN. This includes `sus_lvl = 0` with the level at 0.
- R10: In SUSTAIN the level holds when `perc_mode` is 0. When `perc_mode` is 1, it adds the release-rate increment and saturates at 127.
- R11: While `key_on` is low, any phase other than RELEASE becomes RELEASE on the next clock with the level unchanged. In RELEASE the level adds the release increment and saturates at 127.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_on | input | 1 | Key level; a rise starts the note and low releases it |
| perc_mode | input | 1 | Sustain keeps rising at the release rate |
| atk_rate | input | 6 | Effective attack rate |
| dec_rate | input | 6 | Effective decay rate |
| rel_rate | input | 6 | Effective release rate |
| sus_lvl | input | 4 | Sustain level, compared with level bits [6:3] |
| eg_cnt | input | CNT_W | Shared envelope counter |
| eg_att | output | 7 | Current attenuation |
| eg_phase | output | 3 | Current phase code |

## Verification
Every result of this block is registered once. A change on `key_on`, a rate input or `eg_cnt` therefore shows on `eg_att` and `eg_phase` exactly one rising edge later. The bench drives all inputs on the falling edge and advances its arithmetic model with the same values. It then compares both outputs at the next falling edge, so every clock of every phase trajectory is checked.

// File: rtl/eg_pkg.sv
package eg_pkg;
    localparam int ATT_W   = 7;
    localparam int RATE_W  = 6;
    localparam int SL_W    = ATT_W - 3;
    localparam logic [ATT_W-1:0] ATT_MAX = {ATT_W{1'b1}};

    typedef enum logic [2:0] {
        PH_DUMP    = 3'd0,
        PH_ATTACK  = 3'd1,
        PH_DECAY   = 3'd2,
        PH_SUSTAIN = 3'd3,
        PH_RELEASE = 3'd4
    } eg_phase_e;
endpackage

// File: rtl/eg_rate_gate.sv
module eg_rate_gate #(
    parameter int CNT_W = 16
) (
    input  logic [eg_pkg::RATE_W-1:0] rate,
    input  logic [CNT_W-1:0]          cnt,
    output logic                      tick,
    output logic [1:0]                inc
);
    logic [3:0]       grp;
    logic [1:0]       sub;
    logic [3:0]       sh;
    logic [CNT_W-1:0] mask;
    logic [CNT_W-1:0] shifted;
    logic [3:0]       k;
    logic             odd;
    logic             extra13;

    assign grp = rate[5:2];
    assign sub = rate[1:0];

    always_comb begin
        sh      = (grp >= 4'd13) ? 4'd0 : 4'(4'd13 - grp);
        mask    = (CNT_W'(1) << sh) - CNT_W'(1);
        shifted = cnt >> sh;
        k       = shifted[3:0];
        odd     = k[0];
        tick    = (grp != 4'd0) && ((cnt & mask) == '0);
        unique case (sub)
            2'd0: extra13 = 1'b0;
            2'd1: extra13 = (k[3:2] == 2'b01);
            2'd2: extra13 = k[2];
            default: extra13 = (k >= 4'd4);
        endcase
        if (grp == 4'd15) begin
            inc = 2'd2;
        end else if (grp == 4'd14) begin
            inc = 2'd1 + {1'b0, extra13};
        end else if (grp == 4'd13) begin
            inc = {1'b0, odd | extra13};
        end else begin
            unique case (sub)
                2'd0: inc = {1'b0, odd};
                2'd1: inc = {1'b0, odd | (k[2:0] == 3'd4)};
                2'd2: inc = {1'b0, odd | (k[1:0] == 2'd2)};
                default: inc = {1'b0, k[2:0] != 3'd0};
            endcase
        end
    end
endmodule

// File: rtl/eg_attack_step.sv
module eg_attack_step (
    input  logic [eg_pkg::ATT_W-1:0] att,
    input  logic [1:0]               inc,
    output logic [eg_pkg::ATT_W-1:0] att_next,
    output logic                     at_min
);
    localparam int PW = eg_pkg::ATT_W + 3;
    logic [PW-1:0] prod;
    logic [PW-1:0] delta;

    always_comb begin
        prod     = (PW'(att) + PW'(1)) * PW'(inc) + PW'(3);
        delta    = prod >> 2;
        at_min   = (delta >= PW'(att));
        att_next = at_min ? '0 : eg_pkg::ATT_W'(PW'(att) - delta);
    end
endmodule

// File: rtl/eg_level_add.sv
module eg_level_add (
    input  logic [eg_pkg::ATT_W-1:0] att,
    input  logic [1:0]               inc,
    output logic [eg_pkg::ATT_W-1:0] sum
);
    logic [eg_pkg::ATT_W:0] raw;

    always_comb begin
        raw = {1'b0, att} + (eg_pkg::ATT_W+1)'(inc);
        sum = raw[eg_pkg::ATT_W] ? eg_pkg::ATT_MAX : raw[eg_pkg::ATT_W-1:0];
    end
endmodule

// File: rtl/eg_operator.sv
module eg_operator #(
    parameter int          CNT_W     = 16,
    parameter logic [5:0]  DUMP_RATE = 6'd56
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        key_on,
    input  logic                        perc_mode,
    input  logic [eg_pkg::RATE_W-1:0]   atk_rate,
    input  logic [eg_pkg::RATE_W-1:0]   dec_rate,
    input  logic [eg_pkg::RATE_W-1:0]   rel_rate,
    input  logic [eg_pkg::SL_W-1:0]     sus_lvl,
    input  logic [CNT_W-1:0]            eg_cnt,
    output logic [eg_pkg::ATT_W-1:0]    eg_att,
    output logic [2:0]                  eg_phase
);
    import eg_pkg::*;

    localparam int N_SRC = 4;
    localparam int S_DMP = 0;
    localparam int S_ATK = 1;
    localparam int S_DEC = 2;
    localparam int S_REL = 3;

    eg_phase_e        ph_q, ph_d;
    logic [ATT_W-1:0] att_q, att_d;
    logic             key_q;

    logic [RATE_W-1:0] rate_src [N_SRC];
    logic [N_SRC-1:0]  tick_v;
    logic [1:0]        inc_v    [N_SRC];

    assign rate_src[S_DMP] = DUMP_RATE;
    assign rate_src[S_ATK] = atk_rate;
    assign rate_src[S_DEC] = dec_rate;
    assign rate_src[S_REL] = rel_rate;

    for (genvar g = 0; g < N_SRC; g++) begin : g_gate
        eg_rate_gate #(.CNT_W(CNT_W)) u_gate (
            .rate (rate_src[g]),
            .cnt  (eg_cnt),
            .tick (tick_v[g]),
            .inc  (inc_v[g])
        );
    end

    // Shared saturating adder: source chosen by phase, gated by that source's tick
    logic [1:0]       add_inc;
    logic [ATT_W-1:0] add_sum;

    always_comb begin
        add_inc = 2'd0;
        unique case (ph_q)
            PH_DUMP:    if (tick_v[S_DMP]) add_inc = inc_v[S_DMP];
            PH_DECAY:   if (tick_v[S_DEC]) add_inc = inc_v[S_DEC];
            PH_SUSTAIN: if (tick_v[S_REL] && perc_mode) add_inc = inc_v[S_REL];
            PH_RELEASE: if (tick_v[S_REL]) add_inc = inc_v[S_REL];
            default:    add_inc = 2'd0;
        endcase
    end

    eg_level_add u_add (.att(att_q), .inc(add_inc), .sum(add_sum));

    logic [1:0]       atk_inc;
    logic [ATT_W-1:0] atk_next;
    logic             atk_min;

    assign atk_inc = tick_v[S_ATK] ? inc_v[S_ATK] : 2'd0;

    eg_attack_step u_atk (.att(att_q), .inc(atk_inc), .att_next(atk_next), .at_min(atk_min));

    logic key_rise;
    logic atk_fast;
    assign key_rise = key_on & ~key_q;
    assign atk_fast = (atk_rate[5:2] == 4'hF);

    // Next-state and next-level logic
    always_comb begin
        ph_d  = ph_q;
        att_d = att_q;
        if (key_rise) begin
            ph_d = PH_DUMP;
        end else if (!key_on) begin
            if (ph_q != PH_RELEASE) ph_d = PH_RELEASE;
            else                    att_d = add_sum;
        end else begin
            unique case (ph_q)
                PH_DUMP: begin
                    att_d = add_sum;
                    if (add_sum == ATT_MAX) ph_d = PH_ATTACK;
                end
                PH_ATTACK: begin
                    if (atk_fast || att_q == '0) begin
                        att_d = '0;
                        ph_d  = PH_DECAY;
                    end else begin
                        att_d = atk_next;
                        if (atk_min) ph_d = PH_DECAY;
                    end
                end
                PH_DECAY: begin
                    att_d = add_sum;
                    if (add_sum[ATT_W-1:3] == sus_lvl) ph_d = PH_SUSTAIN;
                end
                PH_SUSTAIN: att_d = add_sum;
                PH_RELEASE: att_d = add_sum;
                default: begin
                    ph_d  = PH_RELEASE;
                    att_d = ATT_MAX;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_RELEASE;
            att_q <= ATT_MAX;
            key_q <= 1'b0;
        end else begin
            ph_q  <= ph_d;
            att_q <= att_d;
            key_q <= key_on;
        end
    end

    // Outputs
    always_comb begin
        eg_att   = att_q;
        eg_phase = ph_q;
    end

    assert_keyon_dump_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (key_on && !key_q) |=> (eg_phase == PH_DUMP && $stable(eg_att)));

    assert_keyoff_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_on && ph_q != PH_RELEASE) |=> (eg_phase == PH_RELEASE && $stable(eg_att)));

    assert_release_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_RELEASE && !key_on && !tick_v[S_REL]) |=> $stable(eg_att));

    assert_attack_falls_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_ATTACK && key_on) |=> (eg_att <= $past(eg_att)));

    assert_fast_skip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_ATTACK && key_on && key_q && atk_fast) |=> (eg_phase == PH_DECAY && eg_att == '0));

    assert_dump_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_DUMP && key_on && key_q && att_q == ATT_MAX) |=> (eg_phase == PH_ATTACK));

    assert_sustain_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_DECAY && key_on && key_q) |=> (eg_phase != PH_SUSTAIN || eg_att[ATT_W-1:3] == $past(sus_lvl)));

    assert_sustain_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_SUSTAIN && key_on && key_q && !perc_mode) |=> $stable(eg_att));
endmodule

// File: tb/tb_eg_operator.sv
module tb_eg_operator;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic key_on = 1'b0;
    logic perc_mode = 1'b0;
    logic [5:0] atk_rate = '0, dec_rate = '0, rel_rate = '0;
    logic [3:0] sus_lvl = '0;
    logic [CNT_W-1:0] eg_cnt = '0;
    logic [6:0] eg_att;
    logic [2:0] eg_phase;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    int m_ph, m_att, m_kq;
    string m_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    eg_operator #(.CNT_W(CNT_W), .DUMP_RATE(6'd56)) dut (
        .clk(clk), .rst_n(rst_n), .key_on(key_on), .perc_mode(perc_mode),
        .atk_rate(atk_rate), .dec_rate(dec_rate), .rel_rate(rel_rate),
        .sus_lvl(sus_lvl), .eg_cnt(eg_cnt), .eg_att(eg_att), .eg_phase(eg_phase)
    );

    // Rate model from R2, R3, R4
    function automatic int m_tick(int rate, int cnt);
        int g = rate / 4;
        int sh = (g >= 13) ? 0 : 13 - g;
        if (g == 0) return 0;
        return ((cnt % (1 << sh)) == 0) ? 1 : 0;
    endfunction

    function automatic int m_inc(int rate, int cnt);
        int g = rate / 4;
        int s = rate % 4;
        int sh = (g >= 13) ? 0 : 13 - g;
        int k = (cnt / (1 << sh)) % 16;
        int odd = k % 2;
        int ex;
        if (g == 15) return 2;
        if (s == 0) ex = 0;
        else if (s == 1) ex = (k / 4 == 1) ? 1 : 0;
        else if (s == 2) ex = (k / 4) % 2;
        else ex = (k >= 4) ? 1 : 0;
        if (g == 14) return 1 + ex;
        if (g == 13) return (odd == 1 || ex == 1) ? 1 : 0;
        if (s == 0) return odd;
        if (s == 1) return (odd == 1 || k % 8 == 4) ? 1 : 0;
        if (s == 2) return (odd == 1 || k % 4 == 2) ? 1 : 0;
        return (k % 8 != 0) ? 1 : 0;
    endfunction

    function automatic int sat(int v);
        return (v > 127) ? 127 : v;
    endfunction

    function automatic int step_amt(int rate, int cnt);
        return (m_tick(rate, cnt) == 1) ? m_inc(rate, cnt) : 0;
    endfunction

    // Advance the model over one rising edge using the currently driven inputs
    task automatic model_edge();
        int c = int'(eg_cnt);
        int a = m_att;
        int rt = (atk_rate / 4 <= 12) ? 3 : 4;
        if (key_on && m_kq == 0) begin
            m_ph = 0; m_tag = "R5";
        end else if (!key_on) begin
            if (m_ph != 4) begin m_ph = 4; m_tag = "R11"; end
            else begin
                m_att = sat(a + step_amt(rel_rate, c));
                m_tag = (rel_rate / 4 <= 12) ? "R11 rate R3" : "R11 rate R4";
            end
        end else begin
            case (m_ph)
                0: begin
                    m_att = sat(a + step_amt(56, c));
                    if (m_att == 127) m_ph = 1;
                    m_tag = "R6 rate R4";
                end
                1: begin
                    if (atk_rate / 4 == 15) begin
                        m_att = 0; m_ph = 2; m_tag = "R8";
                    end else if (a == 0) begin
                        m_ph = 2; m_tag = "R7";
                    end else begin
                        int d = ((a + 1) * step_amt(atk_rate, c) + 3) / 4;
                        if (d >= a) begin m_att = 0; m_ph = 2; end
                        else m_att = a - d;
                        m_tag = (rt == 3) ? "R7 rate R3" : "R7 rate R4";
                    end
                end
                2: begin
                    m_att = sat(a + step_amt(dec_rate, c));
                    if (m_att / 8 == int'(sus_lvl)) m_ph = 3;
                    m_tag = (dec_rate / 4 <= 12) ? "R9 rate R3 R2" : "R9 rate R4";
                end
                3: begin
                    if (perc_mode) m_att = sat(a + step_amt(rel_rate, c));
                    m_tag = "R10";
                end
                default: begin
                    m_att = sat(a + step_amt(rel_rate, c));
                    m_tag = "R11";
                end
            endcase
        end
        m_kq = key_on ? 1 : 0;
    endtask

    task automatic check(string tag);
        vectors++;
        if (int'(eg_att) != m_att || int'(eg_phase) != m_ph) begin
            fails++;
            $display("FAIL %s: att=%0d phase=%0d expected att=%0d phase=%0d (cnt=%0d)",
                     tag, eg_att, eg_phase, m_att, m_ph, eg_cnt);
        end
    endtask

    // At a falling edge: model the coming rising edge, wait, compare
    task automatic cycle(int stride);
        model_edge();
        @(negedge clk);
        check(m_tag);
        eg_cnt = eg_cnt + CNT_W'(stride);
    endtask

    task automatic run(int ar, int dr, int rr, int sl, int pc, int stride, int on_n, int off_n);
        atk_rate = 6'(ar); dec_rate = 6'(dr); rel_rate = 6'(rr);
        sus_lvl = 4'(sl); perc_mode = pc[0];
        key_on = 1'b1;
        for (int i = 0; i < on_n; i++) cycle(stride);
        key_on = 1'b0;
        for (int i = 0; i < off_n; i++) cycle(stride);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        m_ph = 4; m_att = 127; m_kq = 0; m_tag = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset state");
        @(negedge clk);
        check("R1 idle after reset");

        // Sweep of sustain level, percussive mode and rate groups 11..15
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 16; i++) begin
                int ar = (i < 4) ? 52 + i : (i < 8) ? 56 + (i - 4) : (i < 10) ? 60 + (i - 8) : 40 + i;
                int dr = 48 + (i * 3) % 12;
                int rr = 44 + (i * 5) % 16;
                run(ar, dr, rr, i, p, 1, 900, 200);
            end
        end

        // Retrigger during decay and during partial release (R5, R11)
        run(56, 50, 60, 9, 0, 1, 150, 3);
        run(57, 49, 44, 12, 1, 1, 300, 40);
        run(63, 51, 52, 15, 0, 1, 400, 260);

        // Slow groups with sparse ticks via a wide counter stride (R2, R3)
        run(60, 4, 8, 1, 1, 1024, 400, 300);
        run(60, 6, 11, 2, 0, 512, 300, 300);
        run(36, 30, 21, 3, 1, 64, 600, 400);

        // Infinite rates: attack stalls at max, decay stalls at zero (R2, R7)
        run(0, 0, 0, 5, 0, 1, 200, 50);
        run(61, 0, 59, 5, 1, 1, 200, 200);
        // Sustain level zero with fastest attack reaches sustain at zero (R9)
        run(62, 0, 48, 0, 0, 1, 200, 100);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule